// File: doc/BRIEF.md
# GPIO Pull-Up and Open-Drain Controller

This block holds the pad-configuration state for one four-pin I/O port. Two small registers, a pull-up enable register and an open-drain enable register, are written and read over a simple CPU register interface. From them, and from the pin-function context supplied by neighbouring logic, the block drives a pull-up enable and an output-driver mode for every pin.

A pin's pull-up switches on only while its pull-up bit is set and the pin is acting as an input. In modes other than mode 7, a pin is an input only if all three of these hold: its direction bit selects input, the serial peripheral leaves it as an input, and it is not assigned as an address output. In mode 7 the address assignment plays no part. An open-drain bit selects an open-drain NMOS driver in place of a push-pull CMOS driver, except on pins assigned as address outputs. Those pins are always push-pull.

The two registers follow different reset rules. Power-on reset and hardware standby clear both registers. Manual reset clears only the pull-up register. Software standby freezes both. Every output is registered, so each one reflects the register state and input conditions of the previous cycle.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: Power-on reset clears both registers, both output vectors and the read data. Once reset is released, every output reads 0.
- R2: When `bus_wr` is high with `bus_sel`=0, the pull-up register takes `bus_wdata[3:0]`. With `bus_sel`=1, the open-drain register takes it. When `bus_rd` is high, the selected register appears in `bus_rdata[3:0]` on the next cycle. Otherwise `bus_rdata` holds its value.
- R3: Bits 7..4 of both registers ignore writes and always read back as 0.
- R4: In any mode other than 7, `pu_en[i]` is 1 one cycle after the following inputs hold: pull-up bit i is 1, `pin_dir[i]`=0 (0 means input), `ser_input[i]`=1 and `addr_out[i]`=0.
- R5: In mode 7 (`op_mode`=3'd7), `addr_out` has no effect on `pu_en`.
- R6: `od_en[i]` is 1 one cycle after open-drain bit i is 1 and `addr_out[i]`=0. An address-output pin always has `od_en[i]`=0, which means push-pull.
- R7: Manual reset clears the pull-up register. The open-drain register keeps its value.
- R8: Hardware standby clears both registers and both output vectors, in the same way as power-on reset.
- R9: While software standby is asserted, both registers keep their contents and writes are ignored.
- R10: If power-on reset and manual reset are asserted together, power-on reset wins and clears the open-drain register as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active-high |
| man_rst | input | 1 | Manual reset, synchronous, active-high |
| hw_stby | input | 1 | Hardware standby, clears like power-on reset |
| sw_stby | input | 1 | Software standby, freezes registers |
| op_mode | input | 3 | Operating mode; 7 drops the address term from the input test |
| pin_dir | input | 4 | Direction per pin, 1 = output |
| ser_input | input | 4 | 1 = serial-peripheral settings leave the pin as input |
| addr_out | input | 4 | 1 = pin assigned as address output |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 pull-up, 1 open-drain |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, bits 7..4 zero |
| pu_en | output | 4 | Pull-up enable per pin |
| od_en | output | 4 | 1 = open-drain driver, 0 = push-pull |

## Verification
The assertions check the following on every cycle:
- Each reset or standby rule leaves the registers in the state it requires. This covers the manual-reset hold of the open-drain register, the software-standby freeze and the power-on clear.
- No pull-up is ever enabled on a pin that was set to output.
- No address-output pin is ever given an open-drain driver.
- Reserved read bits always come back as zero.

Some behaviours can only be shown by the bench's scenarios. These are the exact mode-dependent input decision, including mode 7 ignoring the address term, the read-back of written values, the rejection of writes during standby, and the priority of power-on reset over manual reset. The bench compares all three outputs against its reference model on every clock.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  typedef enum logic {
    SEL_PULL = 1'b0,
    SEL_ODRN = 1'b1
  } reg_sel_e;

  localparam logic [2:0] MODE_NO_ADDR = 3'd7;
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int W          = 4,
  parameter bit CLR_ON_MAN = 1'b1
) (
  input  logic         clk,
  input  logic         hard_clr,
  input  logic         man_rst,
  input  logic         sw_stby,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  generate
    if (CLR_ON_MAN) begin : g_man_clear
      always_ff @(posedge clk) begin
        if (hard_clr || man_rst) q <= '0;
        else if (wr_en && !sw_stby) q <= wdata;
      end
    end else begin : g_man_hold
      always_ff @(posedge clk) begin
        if (hard_clr) q <= '0;
        else if (wr_en && !sw_stby && !man_rst) q <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_pin_gate.sv
module gpio_pin_gate #(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             hard_clr,
  input  logic             no_addr_mode,
  input  logic [PIN_W-1:0] pu_q,
  input  logic [PIN_W-1:0] od_q,
  input  logic [PIN_W-1:0] pin_dir,
  input  logic [PIN_W-1:0] ser_input,
  input  logic [PIN_W-1:0] addr_out,
  output logic [PIN_W-1:0] pu_en,
  output logic [PIN_W-1:0] od_en
);
  genvar i;
  generate
    for (i = 0; i < PIN_W; i++) begin : g_pin
      logic is_input;
      always_comb
        is_input = !pin_dir[i] && ser_input[i] && (no_addr_mode || !addr_out[i]);
      always_ff @(posedge clk) begin
        if (hard_clr) begin
          pu_en[i] <= 1'b0;
          od_en[i] <= 1'b0;
        end else begin
          pu_en[i] <= pu_q[i] && is_input;
          od_en[i] <= od_q[i] && !addr_out[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_pad_pkg::*;
#(
  parameter int PIN_W = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             hard_clr,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [PIN_W-1:0] pu_q,
  input  logic [PIN_W-1:0] od_q,
  output logic [BUS_W-1:0] rdata
);
  localparam int PAD_W = BUS_W - PIN_W;
  logic [PIN_W-1:0] pick;

  always_comb pick = (sel == SEL_ODRN) ? od_q : pu_q;

  always_ff @(posedge clk) begin
    if (hard_clr) rdata <= '0;
    else if (rd_en) rdata <= {{PAD_W{1'b0}}, pick};
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int PIN_W  = 4,
  parameter int BUS_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [MODE_W-1:0] op_mode,
  input  logic [PIN_W-1:0]  pin_dir,
  input  logic [PIN_W-1:0]  ser_input,
  input  logic [PIN_W-1:0]  addr_out,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [PIN_W-1:0]  pu_en,
  output logic [PIN_W-1:0]  od_en
);
  logic             hard_clr;
  logic             no_addr_mode;
  logic [PIN_W-1:0] pu_q;
  logic [PIN_W-1:0] od_q;
  logic             unused_hi;
  reg_sel_e         sel;

  assign hard_clr     = por_rst || hw_stby;
  assign no_addr_mode = (op_mode == MODE_W'(MODE_NO_ADDR));
  assign sel          = reg_sel_e'(bus_sel);
  assign unused_hi    = ^bus_wdata[BUS_W-1:PIN_W];

  gpio_cfg_reg #(.W(PIN_W), .CLR_ON_MAN(1'b1)) u_pull_reg (
    .clk(clk), .hard_clr(hard_clr), .man_rst(man_rst), .sw_stby(sw_stby),
    .wr_en(bus_wr && sel == SEL_PULL), .wdata(bus_wdata[PIN_W-1:0]), .q(pu_q)
  );

  gpio_cfg_reg #(.W(PIN_W), .CLR_ON_MAN(1'b0)) u_odrn_reg (
    .clk(clk), .hard_clr(hard_clr), .man_rst(man_rst), .sw_stby(sw_stby),
    .wr_en(bus_wr && sel == SEL_ODRN), .wdata(bus_wdata[PIN_W-1:0]), .q(od_q)
  );

  gpio_pin_gate #(.PIN_W(PIN_W)) u_gate (
    .clk(clk), .hard_clr(hard_clr), .no_addr_mode(no_addr_mode),
    .pu_q(pu_q), .od_q(od_q), .pin_dir(pin_dir), .ser_input(ser_input),
    .addr_out(addr_out), .pu_en(pu_en), .od_en(od_en)
  );

  gpio_rd_port #(.PIN_W(PIN_W), .BUS_W(BUS_W)) u_rd (
    .clk(clk), .hard_clr(hard_clr), .rd_en(bus_rd), .sel(sel),
    .pu_q(pu_q), .od_q(od_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int PIN_W = 4,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             por_rst,
  input logic             man_rst,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic             bus_rd,
  input logic [PIN_W-1:0] pin_dir,
  input logic [PIN_W-1:0] addr_out,
  input logic [PIN_W-1:0] pu_q,
  input logic [PIN_W-1:0] od_q,
  input logic [PIN_W-1:0] pu_en,
  input logic [PIN_W-1:0] od_en,
  input logic [BUS_W-1:0] bus_rdata
);
  // R1 / R8: a hard clear empties both registers and both outputs
  assert_hard_clear_R1: assert property (@(posedge clk)
    (por_rst || hw_stby) |=> (pu_q == '0 && od_q == '0 && pu_en == '0 && od_en == '0));

  // R7: manual reset empties the pull-up register
  assert_man_pull_clear_R7: assert property (@(posedge clk) disable iff (por_rst || hw_stby)
    man_rst |=> pu_q == '0);

  // R7: manual reset leaves the open-drain register alone
  assert_man_odrn_hold_R7: assert property (@(posedge clk) disable iff (por_rst || hw_stby)
    man_rst |=> $stable(od_q));

  // R9: software standby freezes both registers
  assert_sw_freeze_R9: assert property (@(posedge clk) disable iff (por_rst || hw_stby || man_rst)
    sw_stby |=> ($stable(pu_q) && $stable(od_q)));

  // R4: no pull-up on a pin that was an output
  assert_pull_only_input_R4: assert property (@(posedge clk) disable iff (por_rst || hw_stby)
    1'b1 |=> (pu_en & $past(pin_dir)) == '0);

  // R6: address-output pins are never open-drain
  assert_addr_push_pull_R6: assert property (@(posedge clk) disable iff (por_rst || hw_stby)
    1'b1 |=> (od_en & $past(addr_out)) == '0);

  // R3: reserved read bits are zero after any read
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (por_rst || hw_stby)
    bus_rd |=> bus_rdata[BUS_W-1:PIN_W] == '0);
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.PIN_W(PIN_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hw_stby(hw_stby),
  .sw_stby(sw_stby), .bus_rd(bus_rd), .pin_dir(pin_dir), .addr_out(addr_out),
  .pu_q(pu_q), .od_q(od_q), .pu_en(pu_en), .od_en(od_en), .bus_rdata(bus_rdata)
);

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;
  logic       clk = 1'b0;
  logic       por_rst = 1'b1, man_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0;
  logic [2:0] op_mode = 3'd5;
  logic [3:0] pin_dir = 4'h0, ser_input = 4'h0, addr_out = 4'h0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] pu_en, od_en;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_pu = 0, m_od = 0, e_pu = 0, e_od = 0, e_rd = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_pad_ctrl u_dut (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .op_mode(op_mode), .pin_dir(pin_dir),
    .ser_input(ser_input), .addr_out(addr_out), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pu_en(pu_en), .od_en(od_en)
  );

  always @(posedge clk) begin
    int inp;
    cycles++;
    inp = 0;
    for (int i = 0; i < 4; i++)
      if (!pin_dir[i] && ser_input[i] && (op_mode == 3'd7 || !addr_out[i]))
        inp |= (1 << i);
    if (por_rst || hw_stby) begin
      e_pu = 0; e_od = 0; e_rd = 0; m_pu = 0; m_od = 0;
    end else begin
      e_pu = m_pu & inp;
      e_od = m_od & ~int'(addr_out) & 15;
      if (bus_rd) e_rd = bus_sel ? m_od : m_pu;
      if (man_rst) m_pu = 0;
      else if (bus_wr && !sw_stby) begin
        if (bus_sel) m_od = bus_wdata & 15;
        else m_pu = bus_wdata & 15;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      vectors++;
      if (int'(pu_en) != e_pu || int'(od_en) != e_od || int'(bus_rdata) != e_rd) begin
        errors++;
        $display("FAIL %s: pu=%h/%h od=%h/%h rd=%h/%h (actual/expected)",
                 cur_req, pu_en, e_pu[3:0], od_en, e_od[3:0], bus_rdata, e_rd[7:0]);
      end
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d; step();
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(bit sel);
    bus_rd = 1'b1; bus_sel = sel; step();
    bus_rd = 1'b0; step();
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1"; step(3); por_rst = 1'b0; step(2);
    // R2 / R3: writes with reserved bits set, read back
    cur_req = "R2"; wr(0, 8'hF5); wr(1, 8'hAA); rd(0); rd(1);
    cur_req = "R3"; wr(0, 8'hF0); rd(0); wr(0, 8'h9F); rd(0);
    // R4: pull-up gating in mode 5 under several patterns
    cur_req = "R4"; op_mode = 3'd5; ser_input = 4'hF; step(2);
    pin_dir = 4'b0101; step(2);
    ser_input = 4'b0011; step(2);
    addr_out = 4'b1000; pin_dir = 4'h0; ser_input = 4'hF; step(2);
    op_mode = 3'd4; addr_out = 4'b0110; step(2);
    // R5: mode 7 ignores the address term
    cur_req = "R5"; op_mode = 3'd7; step(2); addr_out = 4'hF; step(2);
    op_mode = 3'd6; step(2);
    // R6: open-drain with and without address assignment
    cur_req = "R6"; addr_out = 4'h0; wr(1, 8'h0F); step(2);
    addr_out = 4'b1010; step(2); addr_out = 4'h0; step();
    // R7: manual reset
    cur_req = "R7"; wr(0, 8'h0F); man_rst = 1'b1; wr(1, 8'h03); man_rst = 1'b0;
    step(2); rd(0); rd(1);
    // R9: software standby
    cur_req = "R9"; wr(0, 8'h06); sw_stby = 1'b1; wr(0, 8'h09); wr(1, 8'h00);
    step(2); rd(0); rd(1); sw_stby = 1'b0; step(2);
    // R8: hardware standby
    cur_req = "R8"; hw_stby = 1'b1; step(2); hw_stby = 1'b0; step(2); rd(1); rd(0);
    // R10: power-on beats manual reset
    cur_req = "R10"; wr(1, 8'h0C); wr(0, 8'h0C); step(2);
    por_rst = 1'b1; man_rst = 1'b1; step(); por_rst = 1'b0; man_rst = 1'b0;
    step(2); rd(1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule